// File: doc/BRIEF.md
# Display Bridge Bring-Up Sequencer

This block is a host-side controller that powers up an external display bridge after the supply is stable. It first asks the video source to park its data lanes in the LP11 idle state, with the clock lane already running high-speed. It then cycles the bridge enable pin low and high. Next it writes a configuration table into the bridge and turns on the bridge's PLL. It pulses the soft-reset bit, and finally tells the video source to move its data lanes to high-speed and start streaming. Every wait is a minimum. One down-counter serves all of them, loaded with a whole number of milliseconds multiplied by a clock-cycles-per-millisecond parameter.

Register traffic goes out through a request/acknowledge port to an external serial register master. The configuration table is read through a small index port. When a parameter enables the check phase, the sequencer does three things after video starts. It reads every configured register back. It clears the error flags by writing all ones to the error register, waits one millisecond, and reads that register again. A readback mismatch or a nonzero error value sends the whole sequence back to the lane-idle step. After too many failed attempts the block stops in a sticky failed state. A passing check, or a skipped one, raises a sticky done flag.

Top module: `bridge_bringup_seq`

## Requirements
- R1: After reset, `lanes_idle_req` is 1 and `bridge_en`, `video_go`, `reg_valid`, `done` and `fail` are 0. The block waits in this state until `lanes_idle_ack` is sampled high.
- R2: After the acknowledge, `bridge_en` is held 0 for exactly 10·CYC_PER_MS cycles. It is then held 1 for exactly 10·CYC_PER_MS cycles before the first register request. `reg_valid` is never 1 while `bridge_en` is 0.
- R3: Configuration writes (`reg_write`=1) go out in index order 0 to NUM_CFG-1. `cfg_idx` selects each entry, and `reg_addr`/`reg_wdata` carry the table's `cfg_addr`/`cfg_data`.
- R4: After the last configuration write, the block writes data 0x01 (bit 0, PLL enable) to address 0x0D. It then waits exactly 10·CYC_PER_MS cycles.
- R5: Next it writes data 0x01 (bit 0, soft reset) to address 0x09 and waits exactly 10·CYC_PER_MS cycles.
- R6: After that wait, in the same cycle, `video_go` rises and `lanes_idle_req` falls. The block then waits exactly 5·CYC_PER_MS cycles.
- R7: A request holds `reg_valid`, `reg_write` and `cfg_idx` steady until `reg_ack` is sampled high. Each acknowledged cycle completes exactly one access.
- R8: With CHECK_EN=1, the block reads every configuration address in index order (`reg_write`=0). A `reg_rdata` that differs from `cfg_data` counts as a failure.
- R9: After the readback, the block writes 0xFF to address 0xE5 and waits exactly 1·CYC_PER_MS cycles. It then reads 0xE5. A nonzero value counts as a failure.
- R10: `done` rises when the error read returns 0, or, with CHECK_EN=0, directly after the 5 ms wait. It then stays 1 with `bridge_en` and `video_go` held at 1.
- R11: A failure returns the block to the R1 state and restarts from R2. Failure number MAX_RETRY+1 instead sets a sticky `fail` with `bridge_en`, `video_go`, `lanes_idle_req` and `reg_valid` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bridge_en | output | 1 | Bridge enable pin drive |
| lanes_idle_req | output | 1 | Ask the video source to hold data lanes in LP11 |
| lanes_idle_ack | input | 1 | Video source confirms lanes idle |
| video_go | output | 1 | Ask the video source to go high-speed and stream |
| reg_valid | output | 1 | Register access request |
| reg_write | output | 1 | 1 = write, 0 = read |
| reg_addr | output | AW | Register address |
| reg_wdata | output | DW | Write data |
| reg_ack | input | 1 | Access complete |
| reg_rdata | input | DW | Read data, valid with `reg_ack` |
| cfg_idx | output | $clog2(NUM_CFG+1) | Configuration table index |
| cfg_addr | input | AW | Table address at `cfg_idx` |
| cfg_data | input | DW | Table data at `cfg_idx` |
| done | output | 1 | Bring-up complete (sticky) |
| fail | output | 1 | Retries exhausted (sticky) |

## Verification
The main run corrupts the first configuration readback and makes the first error read nonzero. The third attempt then passes. This separates the readback path from the error-register path, and shows that two failures under a limit of two still end in `done`. A second run keeps the error register nonzero on every attempt, which shows that the third failure leads to `fail` rather than another retry. A parallel instance with the check phase disabled and instant acknowledges must raise `done` on one exact cycle. That cycle pins down the summed lengths of all the waits and shows the skip path issues no reads.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  typedef enum logic [3:0] {
    ST_LANES, ST_EN_LO, ST_EN_HI, ST_CFG, ST_PLL, ST_PLL_W, ST_SRST, ST_SRST_W,
    ST_VID_W, ST_RDBK, ST_CLR, ST_CLR_W, ST_ERR, ST_DONE, ST_FAIL
  } seq_state_t;

  // Bridge register locations whose bit meaning the bridge decodes
  localparam logic [7:0] PLL_REG   = 8'h0D;
  localparam logic [7:0] SRST_REG  = 8'h09;
  localparam logic [7:0] ERR_REG   = 8'hE5;
  localparam logic [7:0] ERR_CLEAR = 8'hFF;
  localparam logic [7:0] BIT0_SET  = 8'h01;

  // Minimum waits in milliseconds
  localparam int MS_ENABLE = 10;
  localparam int MS_PLL    = 10;
  localparam int MS_SRST   = 10;
  localparam int MS_VIDEO  = 5;
  localparam int MS_ERRCLR = 1;
  localparam int MS_MAX    = 10;
  localparam int MSW       = $clog2(MS_MAX + 1);

endpackage

// File: rtl/bringup_ms_timer.sv
module bringup_ms_timer #(
  parameter int CYC_PER_MS = 100000,
  parameter int MAX_MS     = 10,
  parameter int MSW        = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [MSW-1:0] load_ms,
  output logic           zero
);
  localparam int CW = $clog2(MAX_MS * CYC_PER_MS + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;

  always_comb load_val = CW'(int'(load_ms) * CYC_PER_MS - 1);

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R2: a freshly loaded multi-cycle wait is not over on the next cycle
  p_load_runs_r2: assert property (@(posedge clk) disable iff (rst)
    (load && (int'(load_ms) * CYC_PER_MS > 1)) |=> !zero);
endmodule

// File: rtl/bringup_retry.sv
module bringup_retry #(
  parameter int MAX_RETRY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fail_evt,
  output logic give_up
);
  localparam int RW = $clog2(MAX_RETRY + 2);

  logic [RW-1:0] fails;

  always_ff @(posedge clk) begin
    if (rst)                                  fails <= '0;
    else if (fail_evt && !give_up)            fails <= fails + 1'b1;
  end

  assign give_up = fail_evt && (fails == RW'(MAX_RETRY));

  // R11: the failure count never passes the retry limit
  p_fail_bound_r11: assert property (@(posedge clk) disable iff (rst)
    fails <= RW'(MAX_RETRY));
endmodule

// File: rtl/bridge_bringup_seq.sv
module bridge_bringup_seq
  import bringup_pkg::*;
#(
  parameter int       CYC_PER_MS = 100000,
  parameter int       NUM_CFG    = 8,
  parameter bit       CHECK_EN   = 1'b1,
  parameter int       MAX_RETRY  = 3,
  parameter int       AW         = 8,
  parameter int       DW         = 8,
  localparam int      IW         = $clog2(NUM_CFG + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          bridge_en,
  output logic          lanes_idle_req,
  input  logic          lanes_idle_ack,
  output logic          video_go,
  output logic          reg_valid,
  output logic          reg_write,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic          reg_ack,
  input  logic [DW-1:0] reg_rdata,
  output logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_data,
  output logic          done,
  output logic          fail
);
  seq_state_t     st, ns;
  logic [IW-1:0]  idx;
  logic           idx_clr, idx_inc;
  logic           tmr_load, tmr_zero;
  logic [MSW-1:0] tmr_ms;
  logic           fail_evt, give_up;
  logic           last_cfg;

  bringup_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MAX_MS(MS_MAX), .MSW(MSW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_ms(tmr_ms), .zero(tmr_zero));

  bringup_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk(clk), .rst(rst), .fail_evt(fail_evt), .give_up(give_up));

  assign last_cfg = (idx == IW'(NUM_CFG - 1));

  always_comb begin
    ns       = st;
    tmr_load = 1'b0;
    tmr_ms   = '0;
    idx_clr  = 1'b0;
    idx_inc  = 1'b0;
    fail_evt = 1'b0;
    case (st)
      ST_LANES:  if (lanes_idle_ack) begin ns = ST_EN_LO; tmr_load = 1'b1; tmr_ms = MSW'(MS_ENABLE); end
      ST_EN_LO:  if (tmr_zero) begin ns = ST_EN_HI; tmr_load = 1'b1; tmr_ms = MSW'(MS_ENABLE); end
      ST_EN_HI:  if (tmr_zero) begin ns = ST_CFG; idx_clr = 1'b1; end
      ST_CFG:    if (reg_ack) begin
                   if (last_cfg) begin ns = ST_PLL; idx_clr = 1'b1; end
                   else idx_inc = 1'b1;
                 end
      ST_PLL:    if (reg_ack) begin ns = ST_PLL_W; tmr_load = 1'b1; tmr_ms = MSW'(MS_PLL); end
      ST_PLL_W:  if (tmr_zero) ns = ST_SRST;
      ST_SRST:   if (reg_ack) begin ns = ST_SRST_W; tmr_load = 1'b1; tmr_ms = MSW'(MS_SRST); end
      ST_SRST_W: if (tmr_zero) begin ns = ST_VID_W; tmr_load = 1'b1; tmr_ms = MSW'(MS_VIDEO); end
      ST_VID_W:  if (tmr_zero) begin
                   if (CHECK_EN) begin ns = ST_RDBK; idx_clr = 1'b1; end
                   else ns = ST_DONE;
                 end
      ST_RDBK:   if (reg_ack) begin
                   if (reg_rdata != cfg_data) fail_evt = 1'b1;
                   else if (last_cfg) begin ns = ST_CLR; idx_clr = 1'b1; end
                   else idx_inc = 1'b1;
                 end
      ST_CLR:    if (reg_ack) begin ns = ST_CLR_W; tmr_load = 1'b1; tmr_ms = MSW'(MS_ERRCLR); end
      ST_CLR_W:  if (tmr_zero) ns = ST_ERR;
      ST_ERR:    if (reg_ack) begin
                   if (reg_rdata != '0) fail_evt = 1'b1;
                   else ns = ST_DONE;
                 end
      default:   ns = st;
    endcase
    if (fail_evt) begin
      ns      = give_up ? ST_FAIL : ST_LANES;
      idx_clr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_LANES;
      idx            <= '0;
      bridge_en      <= 1'b0;
      lanes_idle_req <= 1'b1;
      video_go       <= 1'b0;
      reg_valid      <= 1'b0;
      reg_write      <= 1'b0;
      done           <= 1'b0;
      fail           <= 1'b0;
    end else begin
      st             <= ns;
      if (idx_clr)      idx <= '0;
      else if (idx_inc) idx <= idx + 1'b1;
      bridge_en      <= ns inside {ST_EN_HI, ST_CFG, ST_PLL, ST_PLL_W, ST_SRST, ST_SRST_W,
                                   ST_VID_W, ST_RDBK, ST_CLR, ST_CLR_W, ST_ERR, ST_DONE};
      lanes_idle_req <= ns inside {ST_LANES, ST_EN_LO, ST_EN_HI, ST_CFG, ST_PLL, ST_PLL_W,
                                   ST_SRST, ST_SRST_W};
      video_go       <= ns inside {ST_VID_W, ST_RDBK, ST_CLR, ST_CLR_W, ST_ERR, ST_DONE};
      reg_valid      <= ns inside {ST_CFG, ST_PLL, ST_SRST, ST_RDBK, ST_CLR, ST_ERR};
      reg_write      <= ns inside {ST_CFG, ST_PLL, ST_SRST, ST_CLR};
      done           <= (ns == ST_DONE);
      fail           <= (ns == ST_FAIL);
    end
  end

  always_comb begin
    case (st)
      ST_CFG, ST_RDBK: reg_addr = cfg_addr;
      ST_PLL:          reg_addr = AW'(PLL_REG);
      ST_SRST:         reg_addr = AW'(SRST_REG);
      ST_CLR, ST_ERR:  reg_addr = AW'(ERR_REG);
      default:         reg_addr = '0;
    endcase
    case (st)
      ST_CFG:          reg_wdata = cfg_data;
      ST_PLL, ST_SRST: reg_wdata = DW'(BIT0_SET);
      ST_CLR:          reg_wdata = DW'(ERR_CLEAR);
      default:         reg_wdata = '0;
    endcase
  end

  assign cfg_idx = idx;

  // R2: no register traffic while the bridge is held disabled
  p_no_access_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    reg_valid |-> bridge_en);
  // R7: an unacknowledged request stays put
  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && !reg_ack) |=> (reg_valid && $stable(reg_write) && $stable(cfg_idx)));
  // R6: streaming starts only out of the soft-reset wait, with lanes released
  p_video_order_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(video_go) |-> ($past(st) == ST_SRST_W && !lanes_idle_req));
  // R1: enable rises only while the lanes are held idle
  p_lanes_first_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(bridge_en) |-> $past(lanes_idle_req));
  // R10: done is sticky with bridge and video held on
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && bridge_en && video_go));
  // R11: fail is sticky with the bridge off
  p_fail_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    fail |=> (fail && !bridge_en && !done));
endmodule

// File: tb/bridge_bringup_seq_bench.sv
`timescale 1ns/1ps
module bridge_bringup_seq_bench;
  localparam int CPM  = 20;
  localparam int NCFG = 6;
  localparam int MAXR = 2;
  localparam int IW   = $clog2(NCFG + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  // main instance signals
  logic          bridge_en, lanes_idle_req, video_go, reg_valid, reg_write, done, fail;
  logic          lanes_idle_ack = 1'b0;
  logic          reg_ack = 1'b0;
  logic [7:0]    reg_addr, reg_wdata;
  logic [7:0]    reg_rdata = 8'h00;
  logic [IW-1:0] cfg_idx;
  logic [7:0]    cfg_addr, cfg_data;

  function automatic logic [7:0] tab_a(input int i); return 8'(8'h10 + 3 * i); endfunction
  function automatic logic [7:0] tab_d(input int i); return 8'(8'h5A ^ (17 * i)); endfunction

  assign cfg_addr = tab_a(int'(cfg_idx));
  assign cfg_data = tab_d(int'(cfg_idx));

  bridge_bringup_seq #(.CYC_PER_MS(CPM), .NUM_CFG(NCFG), .CHECK_EN(1'b1), .MAX_RETRY(MAXR),
                       .AW(8), .DW(8)) u_bridge_bringup_seq (
    .clk(clk), .rst(rst), .bridge_en(bridge_en), .lanes_idle_req(lanes_idle_req),
    .lanes_idle_ack(lanes_idle_ack), .video_go(video_go), .reg_valid(reg_valid),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
    .reg_rdata(reg_rdata), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .done(done), .fail(fail));

  // second instance: check phase skipped, instant acknowledges
  logic          s_en, s_idle, s_vid, s_valid, s_write, s_done, s_fail;
  logic [7:0]    s_addr, s_wdata, s_caddr, s_cdata;
  logic [IW-1:0] s_idx;
  assign s_caddr = tab_a(int'(s_idx));
  assign s_cdata = tab_d(int'(s_idx));

  bridge_bringup_seq #(.CYC_PER_MS(CPM), .NUM_CFG(NCFG), .CHECK_EN(1'b0), .MAX_RETRY(MAXR),
                       .AW(8), .DW(8)) u_skip (
    .clk(clk), .rst(rst), .bridge_en(s_en), .lanes_idle_req(s_idle),
    .lanes_idle_ack(s_idle), .video_go(s_vid), .reg_valid(s_valid),
    .reg_write(s_write), .reg_addr(s_addr), .reg_wdata(s_wdata), .reg_ack(s_valid),
    .reg_rdata(8'h00), .cfg_idx(s_idx), .cfg_addr(s_caddr), .cfg_data(s_cdata),
    .done(s_done), .fail(s_fail));

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // ---------------- video source: lane-idle acknowledge ----------------
  logic [3:0] idle_sh = '0;
  always @(negedge clk) begin
    if (rst) idle_sh = '0;
    else     idle_sh = {idle_sh[2:0], lanes_idle_req};
    lanes_idle_ack = idle_sh[3];
  end

  // ---------------- register master model ----------------
  logic [7:0] bmem [256];
  logic [7:0] err_q [$];
  bit         corrupt_pending = 1'b0;
  int         e5_writes = 0;
  int         wait_c = -1;
  always @(negedge clk) begin
    reg_ack = 1'b0;
    if (rst) wait_c = -1;
    else if (reg_valid) begin
      if (wait_c < 0) wait_c = 2;
      else if (wait_c == 0) begin
        if (reg_write) begin
          if (reg_addr == 8'hE5) begin
            bmem[8'hE5] = (err_q.size() > 0) ? err_q.pop_front() : 8'h00;
            e5_writes++;
          end else bmem[reg_addr] = reg_wdata;
        end else begin
          reg_rdata = bmem[reg_addr];
          if (corrupt_pending && reg_addr != 8'hE5) begin
            reg_rdata = reg_rdata ^ 8'h80;
            corrupt_pending = 1'b0;
          end
        end
        reg_ack = 1'b1;
        wait_c  = -1;
      end else wait_c--;
    end
  end

  // ---------------- reference model: a script of expected steps ----------------
  localparam int K_LANES = 0, K_WAIT = 1, K_WR = 2, K_RD = 3, K_RDZ = 4, K_DONE = 5;
  typedef struct {
    int kind; int ms; logic [7:0] addr; logic [7:0] data; bit en; bit idle; bit vid; string tag;
  } op_t;
  op_t script [$];

  function automatic op_t mk(int k, int ms, logic [7:0] a, logic [7:0] d,
                             bit en, bit idle, bit vid, string tag);
    op_t o;
    o.kind = k; o.ms = ms; o.addr = a; o.data = d; o.en = en; o.idle = idle; o.vid = vid; o.tag = tag;
    return o;
  endfunction

  initial begin
    script.push_back(mk(K_LANES, 0, 0, 0, 0, 1, 0, "R1"));
    script.push_back(mk(K_WAIT, 10, 0, 0, 0, 1, 0, "R2"));
    script.push_back(mk(K_WAIT, 10, 0, 0, 1, 1, 0, "R2"));
    for (int i = 0; i < NCFG; i++) script.push_back(mk(K_WR, 0, tab_a(i), tab_d(i), 1, 1, 0, "R3"));
    script.push_back(mk(K_WR, 0, 8'h0D, 8'h01, 1, 1, 0, "R4"));
    script.push_back(mk(K_WAIT, 10, 0, 0, 1, 1, 0, "R4"));
    script.push_back(mk(K_WR, 0, 8'h09, 8'h01, 1, 1, 0, "R5"));
    script.push_back(mk(K_WAIT, 10, 0, 0, 1, 1, 0, "R5"));
    script.push_back(mk(K_WAIT, 5, 0, 0, 1, 0, 1, "R6"));
    for (int i = 0; i < NCFG; i++) script.push_back(mk(K_RD, 0, tab_a(i), tab_d(i), 1, 0, 1, "R8"));
    script.push_back(mk(K_WR, 0, 8'hE5, 8'hFF, 1, 0, 1, "R9"));
    script.push_back(mk(K_WAIT, 1, 0, 0, 1, 0, 1, "R9"));
    script.push_back(mk(K_RDZ, 0, 8'hE5, 0, 1, 0, 1, "R9"));
    script.push_back(mk(K_DONE, 0, 0, 0, 1, 0, 1, "R10"));
  end

  int pos = 0, rem = 0, m_fails = 0;
  bit m_fail = 1'b0;
  bit armed = 1'b0;
  int since_rst = 0;

  task automatic enter(input int p);
    pos = p;
    if (script[p].kind == K_WAIT) rem = script[p].ms * CPM;
  endtask

  task automatic fault();
    m_fails++;
    if (m_fails > MAXR) m_fail = 1'b1;
    else enter(0);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      enter(0); m_fails = 0; m_fail = 1'b0; armed = 1'b1; since_rst = 0;
    end else begin
      since_rst++;
      if (!m_fail) begin
        case (script[pos].kind)
          K_LANES: if (lanes_idle_ack) enter(pos + 1);
          K_WAIT:  begin rem--; if (rem == 0) enter(pos + 1); end
          K_WR:    if (reg_ack) enter(pos + 1);
          K_RD:    if (reg_ack) begin
                     if (reg_rdata != script[pos].data) fault(); else enter(pos + 1);
                   end
          K_RDZ:   if (reg_ack) begin
                     if (reg_rdata != 8'h00) fault(); else enter(pos + 1);
                   end
          default: ;
        endcase
      end
    end
  end

  function automatic bit cmp(input logic [7:0] act, input logic [7:0] exp, input string what);
    if (act !== exp) begin
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
      return 1'b1;
    end
    return 1'b0;
  endfunction

  // skip-phase instance: done expected after every wait and one cycle per access
  localparam int SKIP_T = 3 + 45 * CPM + NCFG;

  always @(negedge clk) begin
    bit bad;
    op_t o;
    bit e_valid, e_write;
    if (armed && !finished) begin
      bad = 1'b0;
      o = script[pos];
      vectors++;
      if (m_fail) begin
        bad |= cmp(8'(bridge_en), 0, "R11 bridge_en");
        bad |= cmp(8'(lanes_idle_req), 0, "R11 lanes_idle_req");
        bad |= cmp(8'(video_go), 0, "R11 video_go");
        bad |= cmp(8'(reg_valid), 0, "R11 reg_valid");
        bad |= cmp(8'(done), 0, "R11 done");
        bad |= cmp(8'(fail), 1, "R11 fail");
      end else begin
        e_valid = (o.kind == K_WR || o.kind == K_RD || o.kind == K_RDZ);
        e_write = (o.kind == K_WR);
        bad |= cmp(8'(bridge_en), 8'(o.en), {o.tag, " bridge_en (R2)"});
        bad |= cmp(8'(lanes_idle_req), 8'(o.idle), {o.tag, " lanes_idle_req (R1)"});
        bad |= cmp(8'(video_go), 8'(o.vid), {o.tag, " video_go (R6)"});
        bad |= cmp(8'(reg_valid), 8'(e_valid), {o.tag, " reg_valid (R7)"});
        if (e_valid) begin
          bad |= cmp(8'(reg_write), 8'(e_write), {o.tag, " reg_write"});
          bad |= cmp(reg_addr, o.addr, {o.tag, " reg_addr"});
          if (e_write) bad |= cmp(reg_wdata, o.data, {o.tag, " reg_wdata"});
        end
        bad |= cmp(8'(done), 8'(o.kind == K_DONE), "R10 done");
        bad |= cmp(8'(fail), 0, "R11 fail");
      end
      if (!rst) begin
        bad |= cmp(8'(s_done), 8'(since_rst >= SKIP_T), "R10 skip-phase done");
        if (s_valid) bad |= cmp(8'(s_write), 1, "R10 skip-phase issues only writes");
        bad |= cmp(8'(s_fail), 0, "R11 skip-phase fail");
      end
      if (bad) miscompares++;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  task automatic run_until_end(input int limit);
    for (int n = 0; n < limit && !(done || fail); n++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(lanes_idle_req == 1'b1, "R1 reset lanes_idle_req", int'(lanes_idle_req), 1);
    check(bridge_en == 1'b0, "R1 reset bridge_en", int'(bridge_en), 0);
    check(reg_valid == 1'b0, "R1 reset reg_valid", int'(reg_valid), 0);
    check(done == 1'b0 && fail == 1'b0, "R1 reset done/fail", int'(done) + int'(fail), 0);

    // Scenario A: one readback mismatch, one nonzero error read, then a clean pass
    corrupt_pending = 1'b1;
    err_q = '{8'h04};
    e5_writes = 0;
    rst = 1'b0;
    run_until_end(20000);
    check(done == 1'b1, "R10 done after two recoverable failures", int'(done), 1);
    check(fail == 1'b0, "R11 no fail within retry limit", int'(fail), 0);
    check(e5_writes == 2, "R9 error clears issued (R8 attempt skips it)", e5_writes, 2);
    repeat (40) @(negedge clk);
    check(done == 1'b1 && bridge_en == 1'b1 && video_go == 1'b1, "R10 done sticky", int'(done), 1);

    // Scenario B: error register never clears
    rst = 1'b1;
    repeat (3) @(negedge clk);
    err_q = '{8'h01, 8'h02, 8'h03};
    corrupt_pending = 1'b0;
    e5_writes = 0;
    rst = 1'b0;
    run_until_end(20000);
    check(fail == 1'b1, "R11 fail after MAX_RETRY+1 failures", int'(fail), 1);
    check(e5_writes == MAXR + 1, "R11 attempts made", e5_writes, MAXR + 1);
    repeat (40) @(negedge clk);
    check(fail == 1'b1 && bridge_en == 1'b0 && done == 1'b0, "R11 fail sticky, bridge off",
          int'(bridge_en), 0);
    check(s_done == 1'b1, "R10 skip-phase instance done", int'(s_done), 1);
    finish_up();
  end
endmodule